// File: doc/BRIEF.md
# One-Wire Self-Timed Configuration Decoder

This block listens to a single open-drain line that carries two kinds of information. As a static level, the line selects the regulator operating mode. A high level forces fixed-frequency PWM, and a low level held long enough enables power-save. As a pulse stream, the line carries two-byte configuration frames. The block decodes those frames into three 5-bit voltage-setting registers.

Each bit is framed by two falling edges. The bit value comes from comparing the low part with the high part of that period, so the block needs no knowledge of the bit rate. A frame is a device address byte followed by a command byte. Each byte is preceded by a high start interval and closed by a low end-of-stream interval.

When the command byte asks for it and the whole frame was good, the block answers by pulling the line low for a fixed time after a fixed delay. All intervals are parameters counted in system clock cycles. The line passes through a two-flop synchroniser before any edge is taken.

Top module: `owd_cfg_decoder`

## Requirements
- R1: A bit is 1 when its high time is at least twice its low time, and 0 when its low time is at least twice its high time. Both times are measured in clock cycles between two consecutive falling edges, and the exact 2:1 ratio qualifies.
- R2: The first byte, sent MSB first, must equal 0x4E. Any other value leaves all registers unchanged and gives no acknowledge.
- R3: The second byte, sent MSB first, carries an acknowledge request in bit 7, a select in bits 6:5 and a value in bits 4:0. Select 0 writes `rail1_hi`, select 1 writes `rail1_lo` and select 2 writes `rail2`. The write takes place when the end-of-stream of the second byte completes.
- R4: Select 3 writes no register, but a frame that is otherwise valid and requests an acknowledge is still acknowledged.
- R5: A bit whose timing meets neither 2:1 criterion drops the frame, with no write and no acknowledge.
- R6: A byte starts only at a falling edge preceded by at least START_CYC high cycles. A shorter high interval before the second byte drops the frame.
- R7: After the eighth bit of a byte, the line must stay low for EOS_CYC cycles. A rise before that drops the frame.
- R8: A valid frame with bit 7 set drives `ack_oe` high for exactly ACK_LEN_CYC cycles. The pulse begins ACK_DLY_CYC cycles after the final falling edge is registered, which is ACK_DLY_CYC+3 cycles after that edge reaches `line_in`. Without the request, `ack_oe` stays low.
- R9: When the synchronised line has been low for TIMEOUT_CYC cycles, `psave_en` rises and any frame in progress is dropped. A high line clears `psave_en`, and `psave_en` is never high while a byte is being received.
- R10: After reset, the registers hold their parameter defaults, and `ack_oe` and `psave_en` are low.
- R11: The same frame decodes to the same result at different bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Resolved level of the shared line, asynchronous |
| ack_oe | output | 1 | Enable of the open-drain pull-down |
| rail1_hi | output | 5 | Rail 1 high default setting |
| rail1_lo | output | 5 | Rail 1 low default setting |
| rail2 | output | 5 | Rail 2 setting |
| psave_en | output | 1 | Power-save enabled; low means PWM forced |

## Verification
The bench builds the block with START_CYC=8, EOS_CYC=10, ACK_DLY_CYC=16, ACK_LEN_CYC=12, TIMEOUT_CYC=200 and a 10-bit counter. With these values a full frame, its acknowledge and the trailing power-save timeout fit in a few hundred cycles, so every frame can end in the timeout that returns the decoder to idle. The short start interval lets a bit unit of 3 cycles keep all in-frame high times below the start threshold. Because of this, an aborted frame cannot restart decoding in mid-stream, while a unit of 20 cycles exercises the slow end of the rate range.

// File: rtl/owd_pkg.sv
package owd_pkg;

    localparam logic [7:0] DEV_ADDR = 8'h4E;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_BITS,
        FS_EOS,
        FS_GAP,
        FS_ACKW,
        FS_ACKON
    } fsm_t;

    typedef struct packed {
        logic       ack_req;
        logic [1:0] sel;
        logic [4:0] val;
    } cfg_word_t;

    typedef struct packed {
        logic one;
        logic zero;
    } bit_res_t;

    function automatic bit_res_t judge_bit(input logic [31:0] lo_t, input logic [31:0] hi_t);
        bit_res_t r;
        r.one  = (hi_t >= {lo_t[30:0], 1'b0});
        r.zero = (lo_t >= {hi_t[30:0], 1'b0});
        return r;
    endfunction

endpackage

// File: rtl/owd_line_sync.sv
module owd_line_sync #(
    parameter int CNT_W       = 16,
    parameter int TIMEOUT_CYC = 600
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    output logic             line_s,
    output logic             fall,
    output logic             rise,
    output logic [CNT_W-1:0] run_len,
    output logic             tmo,
    output logic             psave
);
    localparam logic [CNT_W-1:0] TMO_V = CNT_W'(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] MAXC  = {CNT_W{1'b1}};

    logic s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= 1'b1;
            s2      <= 1'b1;
            prev    <= 1'b1;
            run_len <= '0;
            psave   <= 1'b0;
        end else begin
            s1   <= line_in;
            s2   <= s1;
            prev <= s2;
            if (s2 != prev)
                run_len <= CNT_W'(1);
            else if (run_len != MAXC)
                run_len <= run_len + CNT_W'(1);
            if (s2)
                psave <= 1'b0;
            else if (tmo)
                psave <= 1'b1;
        end
    end

    assign line_s = s2;
    assign fall   = prev & ~s2;
    assign rise   = ~prev & s2;
    assign tmo    = ~s2 & ~prev & (run_len == TMO_V);

    // R9
    psave_clr_chk: assert property (@(posedge clk) disable iff (rst) line_s |=> !psave);
    // R9
    psave_set_chk: assert property (@(posedge clk) disable iff (rst) tmo |=> psave);

endmodule

// File: rtl/owd_bit_slicer.sv
module owd_bit_slicer
    import owd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             fall,
    input  logic [CNT_W-1:0] run_len,
    output logic             bit_one,
    output logic             bit_bad
);
    logic [CNT_W-1:0] low_len;
    bit_res_t         jr;

    always_ff @(posedge clk) begin
        if (rst)
            low_len <= '0;
        else if (rise)
            low_len <= run_len;
    end

    assign jr      = judge_bit(32'(low_len), 32'(run_len));
    assign bit_one = jr.one;
    assign bit_bad = ~(jr.one | jr.zero);

    // R1
    bit_class_chk: assert property (@(posedge clk) disable iff (rst)
        fall |-> $onehot0({jr.one, jr.zero}));

endmodule

// File: rtl/owd_frame_fsm.sv
module owd_frame_fsm
    import owd_pkg::*;
#(
    parameter int         CNT_W       = 16,
    parameter int         START_CYC   = 20,
    parameter int         EOS_CYC     = 20,
    parameter int         ACK_DLY_CYC = 40,
    parameter int         ACK_LEN_CYC = 40,
    parameter logic [4:0] RST_HI      = 5'd16,
    parameter logic [4:0] RST_LO      = 5'd8,
    parameter logic [4:0] RST_R2      = 5'd12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_s,
    input  logic             fall,
    input  logic             tmo,
    input  logic [CNT_W-1:0] run_len,
    input  logic             bit_one,
    input  logic             bit_bad,
    output logic             ack_oe,
    output logic             busy,
    output logic [4:0]       rail1_hi,
    output logic [4:0]       rail1_lo,
    output logic [4:0]       rail2
);
    localparam logic [CNT_W-1:0] START_V = CNT_W'(START_CYC);
    localparam logic [CNT_W-1:0] EOS_V   = CNT_W'(EOS_CYC - 1);
    localparam logic [CNT_W-1:0] ADLY_V  = CNT_W'(ACK_DLY_CYC - 1);
    localparam logic [CNT_W-1:0] ALEN_V  = CNT_W'(ACK_LEN_CYC - 1);

    fsm_t             st;
    logic [2:0]       bit_idx;
    logic             second;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] tmr;
    cfg_word_t        w;

    assign w    = shreg;
    assign busy = (st == FS_BITS) || (st == FS_EOS) || (st == FS_GAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= FS_IDLE;
            bit_idx  <= '0;
            second   <= 1'b0;
            shreg    <= '0;
            tmr      <= '0;
            ack_oe   <= 1'b0;
            rail1_hi <= RST_HI;
            rail1_lo <= RST_LO;
            rail2    <= RST_R2;
        end else begin
            tmr <= tmr + CNT_W'(1);
            if (tmo) begin
                st     <= FS_IDLE;
                ack_oe <= 1'b0;
            end else begin
                case (st)
                    FS_IDLE: if (fall && run_len >= START_V) begin
                        st      <= FS_BITS;
                        bit_idx <= '0;
                        second  <= 1'b0;
                    end
                    FS_BITS: if (fall) begin
                        if (bit_bad) begin
                            st <= FS_IDLE;
                        end else begin
                            shreg   <= {shreg[6:0], bit_one};
                            bit_idx <= bit_idx + 3'd1;
                            if (bit_idx == 3'd7) begin
                                st  <= FS_EOS;
                                tmr <= '0;
                            end
                        end
                    end
                    FS_EOS: if (line_s) begin
                        st <= FS_IDLE;
                    end else if (tmr == EOS_V) begin
                        if (!second) begin
                            st <= (shreg == DEV_ADDR) ? FS_GAP : FS_IDLE;
                        end else begin
                            case (w.sel)
                                2'd0:    rail1_hi <= w.val;
                                2'd1:    rail1_lo <= w.val;
                                2'd2:    rail2    <= w.val;
                                default: ;
                            endcase
                            st <= w.ack_req ? FS_ACKW : FS_IDLE;
                        end
                    end
                    FS_GAP: if (fall) begin
                        if (run_len >= START_V) begin
                            st      <= FS_BITS;
                            bit_idx <= '0;
                            second  <= 1'b1;
                        end else begin
                            st <= FS_IDLE;
                        end
                    end
                    FS_ACKW: if (tmr == ADLY_V) begin
                        ack_oe <= 1'b1;
                        st     <= FS_ACKON;
                        tmr    <= '0;
                    end
                    FS_ACKON: if (tmr == ALEN_V) begin
                        ack_oe <= 1'b0;
                        st     <= FS_IDLE;
                    end
                    default: st <= FS_IDLE;
                endcase
            end
        end
    end

    logic [CNT_W-1:0] ack_run;
    always_ff @(posedge clk) begin
        if (rst || !ack_oe) ack_run <= '0;
        else                ack_run <= ack_run + CNT_W'(1);
    end

    // R3
    reg_upd_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({rail1_hi, rail1_lo, rail2}) |-> ($past(st) == FS_EOS) && $past(second));
    // R4
    rsvd_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (st == FS_EOS && second && w.sel == 2'd3) |=> $stable({rail1_hi, rail1_lo, rail2}));
    // R8
    ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_oe) |-> $past(st) == FS_ACKW);
    // R8
    ack_len_chk: assert property (@(posedge clk) disable iff (rst)
        ack_oe |-> ack_run < CNT_W'(ACK_LEN_CYC));

endmodule

// File: rtl/owd_cfg_decoder.sv
module owd_cfg_decoder #(
    parameter int         CNT_W       = 16,
    parameter int         START_CYC   = 20,
    parameter int         EOS_CYC     = 20,
    parameter int         ACK_DLY_CYC = 40,
    parameter int         ACK_LEN_CYC = 40,
    parameter int         TIMEOUT_CYC = 600,
    parameter logic [4:0] RST_HI      = 5'd16,
    parameter logic [4:0] RST_LO      = 5'd8,
    parameter logic [4:0] RST_R2      = 5'd12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_in,
    output logic       ack_oe,
    output logic [4:0] rail1_hi,
    output logic [4:0] rail1_lo,
    output logic [4:0] rail2,
    output logic       psave_en
);
    logic             line_s, fall, rise, tmo, bit_one, bit_bad, busy;
    logic [CNT_W-1:0] run_len;

    owd_line_sync #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) sync_i (
        .clk(clk), .rst(rst), .line_in(line_in), .line_s(line_s), .fall(fall),
        .rise(rise), .run_len(run_len), .tmo(tmo), .psave(psave_en)
    );

    owd_bit_slicer #(.CNT_W(CNT_W)) slice_i (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall), .run_len(run_len),
        .bit_one(bit_one), .bit_bad(bit_bad)
    );

    owd_frame_fsm #(
        .CNT_W(CNT_W), .START_CYC(START_CYC), .EOS_CYC(EOS_CYC),
        .ACK_DLY_CYC(ACK_DLY_CYC), .ACK_LEN_CYC(ACK_LEN_CYC),
        .RST_HI(RST_HI), .RST_LO(RST_LO), .RST_R2(RST_R2)
    ) fsm_i (
        .clk(clk), .rst(rst), .line_s(line_s), .fall(fall), .tmo(tmo),
        .run_len(run_len), .bit_one(bit_one), .bit_bad(bit_bad), .ack_oe(ack_oe),
        .busy(busy), .rail1_hi(rail1_hi), .rail1_lo(rail1_lo), .rail2(rail2)
    );

    // R9
    pwm_in_rx_chk: assert property (@(posedge clk) disable iff (rst) busy |-> !psave_en);

endmodule

// File: tb/owd_cfg_decoder_tb.sv
`timescale 1ns/1ps
module owd_cfg_decoder_tb_top;
    localparam int START = 8;
    localparam int EOS   = 10;
    localparam int ADLY  = 16;
    localparam int ALEN  = 12;
    localparam int TMO   = 200;
    localparam logic [4:0] D_HI = 5'd16, D_LO = 5'd8, D_R2 = 5'd12;

    typedef struct {
        logic [4:0] hi;
        logic [4:0] lo;
        logic [4:0] r2;
        bit         ack;
        string      tag;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1, drv = 1'b1;
    logic ack_oe, psave_en, line_in;
    logic [4:0] rail1_hi, rail1_lo, rail2;
    int errors = 0, checks = 0, cyc = 0;
    int frame_seq = 0, seen_seq = 0, fall_cyc = 0, ack_cnt = 0, ack_first = 0;
    bit finished = 0;
    logic [4:0] m_hi = D_HI, m_lo = D_LO, m_r2 = D_R2;
    exp_t q[$];
    event frame_done;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign line_in = drv & ~ack_oe;

    owd_cfg_decoder #(
        .CNT_W(10), .START_CYC(START), .EOS_CYC(EOS), .ACK_DLY_CYC(ADLY),
        .ACK_LEN_CYC(ALEN), .TIMEOUT_CYC(TMO), .RST_HI(D_HI), .RST_LO(D_LO), .RST_R2(D_R2)
    ) dut_i (
        .clk(clk), .rst(rst), .line_in(line_in), .ack_oe(ack_oe), .rail1_hi(rail1_hi),
        .rail1_lo(rail1_lo), .rail2(rail2), .psave_en(psave_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic hold(input logic v, input int n);
        drv = v;
        repeat (n) @(negedge clk);
    endtask

    // ack pulse sampler
    always @(negedge clk) begin
        if (frame_seq != seen_seq) begin
            seen_seq  = frame_seq;
            ack_cnt   = 0;
            ack_first = 0;
        end
        if (ack_oe === 1'b1) begin
            if (ack_cnt == 0) ack_first = cyc;
            ack_cnt++;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            exp_t it;
            @(frame_done);
            if (q.size() == 0) begin
                check(0, "queue", 0, 1);
            end else begin
                it = q.pop_front();
                check(rail1_hi == it.hi, {it.tag, " rail1_hi"}, rail1_hi, it.hi);
                check(rail1_lo == it.lo, {it.tag, " rail1_lo"}, rail1_lo, it.lo);
                check(rail2 == it.r2, {it.tag, " rail2"}, rail2, it.r2);
                if (it.ack) begin
                    check(ack_cnt == ALEN, {it.tag, " R8 ack length"}, ack_cnt, ALEN);
                    check(ack_first - fall_cyc == ADLY + 3, {it.tag, " R8 ack delay"},
                          ack_first - fall_cyc, ADLY + 3);
                end else begin
                    check(ack_cnt == 0, {it.tag, " R8 no ack"}, ack_cnt, 0);
                end
            end
        end
    end

    task automatic send_bit(input bit b, input int u, input bit bad);
        if (bad)      begin hold(0, u);     hold(1, u);     end
        else if (b)   begin hold(0, u);     hold(1, 2 * u); end
        else          begin hold(0, 2 * u); hold(1, u);     end
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [7:0] d, input int u,
                              input int bad, input int gap, input int eos, input string tag);
        exp_t it;
        bit valid;
        valid = (a == 8'h4E) && (bad < 0) && (gap >= START) && (eos >= EOS);
        if (valid) begin
            case (d[6:5])
                2'd0: m_hi = d[4:0];
                2'd1: m_lo = d[4:0];
                2'd2: m_r2 = d[4:0];
                default: ;
            endcase
        end
        it.hi = m_hi; it.lo = m_lo; it.r2 = m_r2; it.ack = valid && d[7]; it.tag = tag;
        q.push_back(it);
        frame_seq++;
        hold(1, 12);
        for (int i = 0; i < 8; i++) send_bit(a[7-i], u, bad == i);
        hold(0, EOS + 2);
        hold(1, gap);
        for (int i = 0; i < 8; i++) send_bit(d[7-i], u, bad == i + 8);
        fall_cyc = cyc;
        hold(0, eos);
        if (eos < EOS) hold(1, 3);
        hold(0, TMO + 8);
        check(psave_en == 1'b1, {tag, " R9 psave after long low"}, psave_en, 1);
        hold(1, 6);
        check(psave_en == 1'b0, {tag, " R9 psave cleared by high"}, psave_en, 0);
        -> frame_done;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rail1_hi == D_HI, "R10 rail1_hi", rail1_hi, D_HI);
        check(rail1_lo == D_LO, "R10 rail1_lo", rail1_lo, D_LO);
        check(rail2 == D_R2, "R10 rail2", rail2, D_R2);
        check(ack_oe == 1'b0, "R10 ack_oe", ack_oe, 0);
        check(psave_en == 1'b0, "R10 psave_en", psave_en, 0);
        hold(1, 20);
        send_frame(8'h4E, 8'h15, 3, -1, 12, EOS + 2, "R1/R3 sel0 no ack");
        send_frame(8'h4E, 8'hAA, 20, -1, 12, EOS + 2, "R11 slow sel1 ack");
        send_frame(8'h4E, 8'hDF, 5, -1, 12, EOS + 2, "R3 sel2 ack");
        send_frame(8'h4F, 8'hC3, 3, -1, 12, EOS + 2, "R2 bad address");
        send_frame(8'h4E, 8'hE7, 3, -1, 12, EOS + 2, "R4 reserved select");
        send_frame(8'h4E, 8'h83, 3, 10, 12, EOS + 2, "R5 ambiguous bit");
        send_frame(8'h4E, 8'h83, 3, -1, 5, EOS + 2, "R6 short start");
        send_frame(8'h4E, 8'h83, 3, -1, 12, 4, "R7 short end of stream");
        send_frame(8'h4E, 8'h04, 3, -1, 12, EOS + 2, "R1 recovery sel0");
        send_frame(8'h4E, 8'hAA, 3, -1, 12, EOS + 2, "R11 fast sel1 ack");
        repeat (4) @(negedge clk);
        check(q.size() == 0, "scoreboard drained", q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule